// File: doc/BRIEF.md
# Exception Status Register Unit

This unit keeps the privileged exception state of a pipelined processor: the exception program counter, the cause word, the status word and a single user/kernel mode bit. When the pipeline raises an exception strobe, the unit captures the faulting instruction address and the cause code, enters kernel mode, and on the next cycle sends a redirect to the handler entry address. A parameter selects the form of that address. It is either one fixed entry point, or a per-cause vector in which entries sit 32 bytes (eight instructions) apart.

Software reads the three registers through a move-from-coprocessor port that takes a register number. Only the status word can be written, through a separate write strobe. A return-from-exception strobe drops back to user mode and redirects fetch to the saved address. Interrupt lines are sampled into pending bits of the cause word. A global enable bit and per-line mask bits in the status word decide whether an interrupt request is raised toward the pipeline.

All pins are plain control and status signals. Strobes act in the single cycle in which they are high. The read port answers combinationally and has no back-pressure. The redirect output is a one-cycle pulse that the fetch stage must accept at once.

Top module: `exc_status_unit`

## Requirements
- R1: After reset the unit is in kernel mode, the redirect pulse is low, and EPC, Cause and Status all read as zero.
- R2: On an exception strobe, EPC is loaded with the supplied PC minus 4 when the PC-advanced flag is 1, and with the supplied PC unchanged when the flag is 0.
- R3: On an exception strobe, the 4-bit cause code is stored in Cause bits 5..2. Cause bits 8+i hold interrupt line i as sampled one clock earlier. All other Cause bits read 0. Code 10 denotes an undefined instruction and code 12 denotes arithmetic overflow.
- R4: The clock edge that accepts an exception sets kernel mode, and in the following cycle the redirect pulse is high for exactly one cycle.
- R5: In single-entry mode (VECTORED=0) the redirect address for every exception is SINGLE_ENTRY, which defaults to 0x80000180.
- R6: In vectored mode (VECTORED=1) the redirect address is VEC_BASE + 32 × cause code.
- R7: In kernel mode, a read of register number 12 returns Status, 13 returns Cause, 14 returns EPC, and any other number returns 0. In kernel mode the privilege flag stays 0.
- R8: A read issued in user mode returns 0 and raises the privilege flag in the same cycle.
- R9: A return strobe without an exception clears kernel mode and produces a one-cycle redirect to the current EPC value.
- R10: When an exception and a return arrive in the same cycle, the exception wins: the unit stays in kernel mode and redirects to the handler.
- R11: A Status write in kernel mode stores only bit 0 (global interrupt enable) and bits 8+i (mask for line i). A Status write in user mode has no effect.
- R12: The interrupt request output is high exactly when the unit is in user mode, Status bit 0 is set, and some pending bit 8+i is set together with its mask bit 8+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Exception strobe |
| exc_code | input | 4 | Cause code of the exception |
| exc_pc | input | 32 | PC supplied with the exception |
| exc_pc_adv | input | 1 | 1 when exc_pc is already the incremented PC |
| eret | input | 1 | Return-from-exception strobe |
| cp_rd_en | input | 1 | Register read request |
| cp_rd_sel | input | 5 | Register number to read |
| cp_rd_data | output | 32 | Read data |
| priv_fault | output | 1 | Read attempted in user mode |
| status_wr_en | input | 1 | Status write strobe |
| status_wr_data | input | 32 | Status write data |
| irq_lines | input | NUM_IRQ | External interrupt lines |
| irq_req | output | 1 | Enabled, unmasked interrupt pending in user mode |
| kernel_mode | output | 1 | 1 in kernel mode |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 32 | Redirect target address |

## Verification
The bound checker covers the rules that can be checked on every cycle. These are the PC correction into EPC, entry into kernel mode with its redirect pulse, the exception winning over a simultaneous return, return to user mode with a redirect to EPC, the zeroed and flagged user-mode reads, the frozen Status under user writes, and the fact that an interrupt request is raised only in user mode. The actual handler addresses in both entry schemes, the exact Cause bit layout including the pending bits, and the register numbering of the read port are shown only by the bench scenarios. To do this, the bench drives two instances, one in each entry mode, with the same stimulus.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN     = 32;
  localparam int CODE_W   = 4;
  localparam int CODE_LSB = 2;
  localparam int PEND_LSB = 8;
  localparam int SEL_W    = 5;
  localparam int PC_STEP  = 4;

  localparam logic [SEL_W-1:0] SEL_STATUS = 5'd12;
  localparam logic [SEL_W-1:0] SEL_CAUSE  = 5'd13;
  localparam logic [SEL_W-1:0] SEL_EPC    = 5'd14;

  localparam logic [CODE_W-1:0] CODE_IRQ   = 4'd0;
  localparam logic [CODE_W-1:0] CODE_UNDEF = 4'd10;
  localparam logic [CODE_W-1:0] CODE_OVF   = 4'd12;
endpackage

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_pkg::*;
#(
  parameter bit              VECTORED     = 1'b0,
  parameter logic [XLEN-1:0] SINGLE_ENTRY = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE     = 32'h8000_0000,
  parameter int              SLOT_LOG2    = 5
) (
  input  logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   handler_pc
);
  generate
    if (VECTORED) begin : g_vectored
      logic [XLEN-1:0] offset;
      always_comb begin
        offset     = {{(XLEN-CODE_W){1'b0}}, code} << SLOT_LOG2;
        handler_pc = VEC_BASE + offset;
      end
    end else begin : g_single
      logic unused_code;
      assign unused_code = ^code;
      assign handler_pc  = SINGLE_ENTRY;
    end
  endgenerate
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int NUM_IRQ = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  input  logic [CODE_W-1:0]  exc_code,
  input  logic [XLEN-1:0]    exc_pc,
  input  logic               exc_pc_adv,
  input  logic [XLEN-1:0]    handler_pc,
  input  logic               eret,
  input  logic               status_wr_en,
  input  logic [XLEN-1:0]    status_wr_data,
  input  logic [NUM_IRQ-1:0] irq_lines,
  output logic               kernel_q,
  output logic [XLEN-1:0]    epc_q,
  output logic [XLEN-1:0]    cause_q,
  output logic [XLEN-1:0]    status_q,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc
);
  localparam logic [XLEN-1:0] IRQ_FIELD =
    ((XLEN'(1) << NUM_IRQ) - XLEN'(1)) << PEND_LSB;
  localparam logic [XLEN-1:0] STATUS_WMASK = IRQ_FIELD | XLEN'(1);

  logic [CODE_W-1:0]  code_q;
  logic [NUM_IRQ-1:0] pend_q;
  logic [XLEN-1:0]    epc_next;

  assign epc_next = exc_pc_adv ? (exc_pc - XLEN'(PC_STEP)) : exc_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kernel_q       <= 1'b1;
      epc_q          <= '0;
      code_q         <= '0;
      pend_q         <= '0;
      status_q       <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      pend_q         <= irq_lines;
      redirect_valid <= 1'b0;
      if (exc_valid) begin
        epc_q          <= epc_next;
        code_q         <= exc_code;
        kernel_q       <= 1'b1;
        redirect_valid <= 1'b1;
        redirect_pc    <= handler_pc;
      end else if (eret) begin
        kernel_q       <= 1'b0;
        redirect_valid <= 1'b1;
        redirect_pc    <= epc_q;
      end
      if (status_wr_en && kernel_q)
        status_q <= status_wr_data & STATUS_WMASK;
    end
  end

  always_comb begin
    cause_q = '0;
    cause_q[CODE_LSB +: CODE_W]   = code_q;
    cause_q[PEND_LSB +: NUM_IRQ]  = pend_q;
  end
endmodule

// File: rtl/exc_read_port.sv
module exc_read_port
  import exc_pkg::*;
(
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic             kernel,
  input  logic [XLEN-1:0]  status_q,
  input  logic [XLEN-1:0]  cause_q,
  input  logic [XLEN-1:0]  epc_q,
  output logic [XLEN-1:0]  rd_data,
  output logic             priv_fault
);
  always_comb begin
    rd_data    = '0;
    priv_fault = rd_en && !kernel;
    if (rd_en && kernel) begin
      case (rd_sel)
        SEL_STATUS: rd_data = status_q;
        SEL_CAUSE:  rd_data = cause_q;
        SEL_EPC:    rd_data = epc_q;
        default:    rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/exc_status_unit.sv
module exc_status_unit
  import exc_pkg::*;
#(
  parameter int              NUM_IRQ      = 6,
  parameter bit              VECTORED     = 1'b0,
  parameter logic [31:0]     SINGLE_ENTRY = 32'h8000_0180,
  parameter logic [31:0]     VEC_BASE     = 32'h8000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  input  logic [3:0]         exc_code,
  input  logic [31:0]        exc_pc,
  input  logic               exc_pc_adv,
  input  logic               eret,
  input  logic               cp_rd_en,
  input  logic [4:0]         cp_rd_sel,
  output logic [31:0]        cp_rd_data,
  output logic               priv_fault,
  input  logic               status_wr_en,
  input  logic [31:0]        status_wr_data,
  input  logic [NUM_IRQ-1:0] irq_lines,
  output logic               irq_req,
  output logic               kernel_mode,
  output logic               redirect_valid,
  output logic [31:0]        redirect_pc
);
  logic [XLEN-1:0] handler_pc;
  logic [XLEN-1:0] epc_q, cause_q, status_q;
  logic            kernel_q;

  exc_vector_gen #(
    .VECTORED(VECTORED), .SINGLE_ENTRY(SINGLE_ENTRY),
    .VEC_BASE(VEC_BASE), .SLOT_LOG2(5)
  ) u_vec (
    .code(exc_code), .handler_pc(handler_pc)
  );

  exc_state_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_pc_adv(exc_pc_adv),
    .handler_pc(handler_pc), .eret(eret),
    .status_wr_en(status_wr_en), .status_wr_data(status_wr_data),
    .irq_lines(irq_lines),
    .kernel_q(kernel_q), .epc_q(epc_q), .cause_q(cause_q),
    .status_q(status_q),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  exc_read_port u_rd (
    .rd_en(cp_rd_en), .rd_sel(cp_rd_sel), .kernel(kernel_q),
    .status_q(status_q), .cause_q(cause_q), .epc_q(epc_q),
    .rd_data(cp_rd_data), .priv_fault(priv_fault)
  );

  assign kernel_mode = kernel_q;
  assign irq_req = !kernel_q && status_q[0] &&
                   |(cause_q[PEND_LSB +: NUM_IRQ] & status_q[PEND_LSB +: NUM_IRQ]);
endmodule

// File: rtl/exc_status_unit_chk.sv
module exc_status_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_valid,
  input logic [31:0] exc_pc,
  input logic        exc_pc_adv,
  input logic        eret,
  input logic        cp_rd_en,
  input logic [31:0] cp_rd_data,
  input logic        priv_fault,
  input logic        status_wr_en,
  input logic        kernel_mode,
  input logic        irq_req,
  input logic        redirect_valid,
  input logic [31:0] redirect_pc,
  input logic [31:0] epc_q,
  input logic [31:0] status_q
);
  p_epc_fix_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> epc_q == ($past(exc_pc_adv) ? $past(exc_pc) - 32'd4 : $past(exc_pc)));

  p_enter_kernel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> kernel_mode && redirect_valid);

  p_exc_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && eret) |=> kernel_mode);

  p_return_user_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !exc_valid) |=> !kernel_mode && redirect_valid && redirect_pc == $past(epc_q));

  p_user_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_rd_en && !kernel_mode) |-> (cp_rd_data == 32'd0) && priv_fault);

  p_status_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr_en && !kernel_mode) |=> $stable(status_q));

  p_irq_user_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !kernel_mode);
endmodule

bind exc_status_unit exc_status_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_pc(exc_pc),
  .exc_pc_adv(exc_pc_adv), .eret(eret), .cp_rd_en(cp_rd_en),
  .cp_rd_data(cp_rd_data), .priv_fault(priv_fault),
  .status_wr_en(status_wr_en), .kernel_mode(kernel_mode), .irq_req(irq_req),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
  .epc_q(epc_q), .status_q(status_q)
);

// File: tb/exc_status_unit_tb_top.sv
`timescale 1ns/1ps
module exc_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic        exc_pc_adv = 1'b0;
  logic        eret = 1'b0;
  logic        cp_rd_en = 1'b0;
  logic [4:0]  cp_rd_sel = '0;
  logic        status_wr_en = 1'b0;
  logic [31:0] status_wr_data = '0;
  logic [5:0]  irq_lines = '0;
  logic [31:0] cp_rd_data, v_rd_data, redirect_pc, v_redirect_pc;
  logic        priv_fault, v_priv_fault, irq_req, v_irq_req;
  logic        kernel_mode, v_kernel_mode, redirect_valid, v_redirect_valid;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  exc_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_pc_adv(exc_pc_adv), .eret(eret),
    .cp_rd_en(cp_rd_en), .cp_rd_sel(cp_rd_sel), .cp_rd_data(cp_rd_data),
    .priv_fault(priv_fault), .status_wr_en(status_wr_en),
    .status_wr_data(status_wr_data), .irq_lines(irq_lines), .irq_req(irq_req),
    .kernel_mode(kernel_mode), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc)
  );

  exc_status_unit #(.VECTORED(1'b1)) dut_vec_i (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_pc_adv(exc_pc_adv), .eret(eret),
    .cp_rd_en(cp_rd_en), .cp_rd_sel(cp_rd_sel), .cp_rd_data(v_rd_data),
    .priv_fault(v_priv_fault), .status_wr_en(status_wr_en),
    .status_wr_data(status_wr_data), .irq_lines(irq_lines), .irq_req(v_irq_req),
    .kernel_mode(v_kernel_mode), .redirect_valid(v_redirect_valid),
    .redirect_pc(v_redirect_pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [4:0] sel, output logic [31:0] d, output logic pf);
    @(negedge clk);
    cp_rd_en = 1'b1; cp_rd_sel = sel;
    #1; d = cp_rd_data; pf = priv_fault;
    cp_rd_en = 1'b0;
  endtask

  task automatic raise_exc(input logic [3:0] code, input logic [31:0] pc, input logic adv);
    @(negedge clk);
    exc_valid = 1'b1; exc_code = code; exc_pc = pc; exc_pc_adv = adv;
    @(negedge clk);
    exc_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic pf;
    check("R1 kernel", 32'(kernel_mode), 32'd1);
    check("R1 redirect", 32'(redirect_valid), 32'd0);
    read_reg(5'd14, d, pf); check("R1 epc", d, 32'd0);
    read_reg(5'd13, d, pf); check("R1 cause", d, 32'd0);
    read_reg(5'd12, d, pf); check("R1 status", d, 32'd0);
    check("R7 no fault in kernel", 32'(pf), 32'd0);
  endtask

  task automatic t_status_write();
    logic [31:0] d; logic pf;
    @(negedge clk);
    status_wr_en = 1'b1; status_wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    status_wr_en = 1'b0;
    read_reg(5'd12, d, pf); check("R11 masked write", d, 32'h0000_3F01);
    @(negedge clk);
    status_wr_en = 1'b1; status_wr_data = 32'h0000_0501;
    @(negedge clk);
    status_wr_en = 1'b0;
    read_reg(5'd12, d, pf); check("R7 status read", d, 32'h0000_0501);
    read_reg(5'd5, d, pf);  check("R7 unknown reg", d, 32'd0);
  endtask

  task automatic t_user_mode();
    logic [31:0] d; logic pf;
    @(negedge clk);
    eret = 1'b1;
    @(negedge clk);
    eret = 1'b0;
    check("R9 user mode", 32'(kernel_mode), 32'd0);
    check("R9 redirect valid", 32'(redirect_valid), 32'd1);
    check("R9 redirect to epc", redirect_pc, 32'd0);
    @(negedge clk);
    check("R9 pulse one cycle", 32'(redirect_valid), 32'd0);
    read_reg(5'd13, d, pf);
    check("R8 user read data", d, 32'd0);
    check("R8 privilege flag", 32'(pf), 32'd1);
    irq_lines = 6'b000001;
    @(negedge clk);
    check("R12 irq raised", 32'(irq_req), 32'd1);
    status_wr_en = 1'b1; status_wr_data = 32'd0;
    @(negedge clk);
    status_wr_en = 1'b0;
    check("R11 user write ignored", 32'(irq_req), 32'd1);
    irq_lines = 6'b000010;
    @(negedge clk);
    check("R12 masked line", 32'(irq_req), 32'd0);
    irq_lines = 6'b000001;
  endtask

  task automatic t_overflow();
    logic [31:0] d; logic pf;
    raise_exc(4'd12, 32'h0000_0050, 1'b1);
    check("R4 kernel entered", 32'(kernel_mode), 32'd1);
    check("R4 redirect valid", 32'(redirect_valid), 32'd1);
    check("R5 single entry", redirect_pc, 32'h8000_0180);
    check("R6 vector code 12", v_redirect_pc, 32'h8000_0180);
    check("R12 no irq in kernel", 32'(irq_req), 32'd0);
    read_reg(5'd14, d, pf); check("R2 epc minus 4", d, 32'h0000_004C);
    read_reg(5'd13, d, pf); check("R3 cause ovf with pending", d, 32'h0000_0130);
    @(negedge clk);
    eret = 1'b1; irq_lines = '0;
    @(negedge clk);
    eret = 1'b0;
    check("R9 return to epc", redirect_pc, 32'h0000_004C);
    check("R9 user after return", 32'(kernel_mode), 32'd0);
  endtask

  task automatic t_undef();
    logic [31:0] d; logic pf;
    raise_exc(4'd10, 32'h0000_0100, 1'b0);
    check("R5 single entry undef", redirect_pc, 32'h8000_0180);
    check("R6 vector code 10", v_redirect_pc, 32'h8000_0140);
    read_reg(5'd14, d, pf); check("R2 epc as given", d, 32'h0000_0100);
    read_reg(5'd13, d, pf); check("R3 cause undef", d, 32'h0000_0028);
  endtask

  task automatic t_collision();
    logic [31:0] d; logic pf;
    @(negedge clk);
    eret = 1'b1;
    @(negedge clk);
    eret = 1'b0;
    check("R9 user before collision", 32'(kernel_mode), 32'd0);
    @(negedge clk);
    exc_valid = 1'b1; eret = 1'b1; exc_code = 4'd3; exc_pc = 32'h0000_0200; exc_pc_adv = 1'b0;
    @(negedge clk);
    exc_valid = 1'b0; eret = 1'b0;
    check("R10 stays kernel", 32'(kernel_mode), 32'd1);
    check("R10 handler wins", redirect_pc, 32'h8000_0180);
    check("R6 vector code 3", v_redirect_pc, 32'h8000_0060);
    read_reg(5'd14, d, pf); check("R10 epc captured", d, 32'h0000_0200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status_write();
    t_user_mode();
    t_overflow();
    t_undef();
    t_collision();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule